// File: doc/BRIEF.md
# Serial ADC Target Model (chip-select, four-wire, busy flag)

This block is a synthesizable stand-in for the serial port of a 16-bit successive-approximation converter. It runs in chip-select mode with a busy indication. A host controller under test drives the convert strobe, the select/data-in line and the serial clock. The model answers on a serial data output, given as a data bit and an output enable. An enable of zero stands for high impedance, and the bench resolves it to logic 1 as a pull-up would.

A conversion starts when the convert strobe rises while the select line is high. The model then waits a set number of system clock cycles. At the end of that wait it latches a 16-bit word from a parallel input. If the select line is low at that point, the model drives the data line low. The host can use this falling line as an interrupt. Each later falling edge of the serial clock puts the next bit on the line, most significant first. The line returns to high impedance on the seventeenth falling edge, or earlier if the select line rises.

The select line may be raised briefly early in the conversion. If it rises again after the minimum conversion time, the model sets a sticky protocol-violation flag and gives no busy indication. All pins are sampled on the system clock, and every output is registered.

Top module: `adci_target`

## Requirements
- R1: While reset is asserted the data enable and the violation flag are 0.
- R2: While idle, with no conversion pending, the data line is driven low (enable 1, data 0) one cycle after the convert strobe and the select line are both seen low; any other idle combination gives enable 0.
- R3: A rising edge of the convert strobe seen while the select line is high starts a conversion. The enable is 0 from the next cycle until the conversion ends.
- R4: A conversion ends CONV_CYC cycles after the cycle that saw the starting edge. If the select line is low then, enable 1 and data 0 appear in the following cycle.
- R5: After the busy indication, falling serial clock edges 1 to 16 each present one bit of the word latched at conversion end: edge k gives bit 16-k. Changes of the parallel input after the latch have no effect.
- R6: The seventeenth falling serial clock edge sets the enable to 0 and returns the model to idle.
- R7: A rising edge of the select line during readout sets the enable to 0 in the next cycle.
- R8: A select-line rise seen while fewer than MIN_CYC conversion cycles have elapsed sets no violation. The busy indication still follows if the line is low at the end.
- R9: A select-line rise seen after MIN_CYC or more conversion cycles sets the violation flag, and the enable stays 0 when that conversion ends. The flag stays set until the next conversion starts, which clears it.
- R10: Serial clock edges while idle or converting change neither the enable nor the bits later read out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_i | input | 1 | Convert strobe from the host |
| sdi_i | input | 1 | Select / data-in line from the host |
| sck_i | input | 1 | Serial clock from the host |
| sample_i | input | DATA_W | Parallel sample word, latched at conversion end |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Data enable; 0 means high impedance |
| viol_o | output | 1 | Sticky protocol-violation flag |

## Verification
A wrong conversion count moves the busy edge. That shows on the enable within one cycle of the expected completion. A fault in the shift path or the bit counter gives a wrong data bit, or an early or late release, within one serial clock period of the first wrong edge. The bench compares the enable, the data bit while enabled, and the violation flag against a behavioural model on every cycle. So a bad internal state shows up at the first cycle where it reaches a port.

// File: rtl/adci_pkg.sv
package adci_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_READ = 2'd2
    } adci_state_e;
endpackage

// File: rtl/adci_edge.sv
// Registers a set of pins and reports which of them went from 0 to 1.
module adci_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = pin_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise_o[i] = pin_i[i] & ~prev_q[i];
    end
endmodule

// File: rtl/adci_timer.sv
// Conversion timer: counts cycles while running, flags minimum time and end.
module adci_timer #(
    parameter int CONV_CYC = 20,
    parameter int MIN_CYC  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic done_o,
    output logic late_o
);
    localparam int CW = $clog2(CONV_CYC);
    localparam logic [CW-1:0] LAST = CW'(CONV_CYC - 1);
    localparam logic [CW-1:0] MINV = CW'(MIN_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)                    cnt_d = '0;
        else if (run_i && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = run_i && (cnt_q == LAST);
    assign late_o = cnt_q >= MINV;

    // R4: the count never passes the last conversion cycle
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R3: a start always restarts counting from zero
    assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == '0));
endmodule

// File: rtl/adci_shift.sv
// Sample holder: parallel load, left shift, most significant bit out.
module adci_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              msb_o
);
    logic [DATA_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i)       sh_d = din_i;
        else if (shift_i) sh_d = {sh_q[DATA_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign msb_o = sh_q[DATA_W-1];

    // R5: a load stores the parallel word unchanged
    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sh_q == $past(din_i)));
endmodule

// File: rtl/adci_target.sv
module adci_target
    import adci_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CONV_CYC = 20,
    parameter int MIN_CYC  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_i,
    input  logic              sdi_i,
    input  logic              sck_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              viol_o
);
    localparam int BW = $clog2(DATA_W + 1);
    localparam logic [BW-1:0] BITS_END = BW'(DATA_W);

    typedef struct packed {
        adci_state_e   st;
        logic [BW-1:0] bits;
        logic          oe;
        logic          dat;
        logic          viol;
    } port_s;

    port_s r_d, r_q;

    logic [2:0] rise;
    logic       cnv_rise, sdi_rise, sck_fall;
    logic       t_start, t_done, t_late;
    logic       sh_load, sh_shift, sh_msb;

    // bit 2 watches the inverted serial clock so its rise is a falling edge
    adci_edge #(.N(3)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({~sck_i, sdi_i, cnv_i}),
        .rise_o (rise)
    );
    assign cnv_rise = rise[0];
    assign sdi_rise = rise[1];
    assign sck_fall = rise[2];

    adci_timer #(.CONV_CYC(CONV_CYC), .MIN_CYC(MIN_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (t_start),
        .run_i   (r_q.st == ST_CONV),
        .done_o  (t_done),
        .late_o  (t_late)
    );

    adci_shift #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .shift_i (sh_shift),
        .din_i   (sample_i),
        .msb_o   (sh_msb)
    );

    always_comb begin
        r_d      = r_q;
        t_start  = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (cnv_rise && sdi_i) begin
                    r_d.st   = ST_CONV;
                    r_d.oe   = 1'b0;
                    r_d.viol = 1'b0;
                    t_start  = 1'b1;
                end else begin
                    r_d.oe  = !cnv_i && !sdi_i;
                    r_d.dat = 1'b0;
                end
            end
            ST_CONV: begin
                r_d.oe = 1'b0;
                if (sdi_rise && t_late) r_d.viol = 1'b1;
                if (t_done) begin
                    sh_load = 1'b1;
                    if (!sdi_i && !r_d.viol) begin
                        r_d.st   = ST_READ;
                        r_d.oe   = 1'b1;
                        r_d.dat  = 1'b0;
                        r_d.bits = '0;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_READ: begin
                if (sdi_rise) begin
                    r_d.oe = 1'b0;
                    r_d.st = ST_IDLE;
                end else if (sck_fall) begin
                    if (r_q.bits == BITS_END) begin
                        r_d.oe = 1'b0;
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.dat  = sh_msb;
                        sh_shift = 1'b1;
                        r_d.bits = r_q.bits + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.bits <= '0;
            r_q.oe   <= 1'b0;
            r_q.dat  <= 1'b0;
            r_q.viol <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sdo_o    = r_q.dat;
    assign sdo_oe_o = r_q.oe;
    assign viol_o   = r_q.viol;

    // R1: reset state of the port outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!r_d.oe || r_q.st == ST_IDLE);
        end
    end
    // R3: a valid start puts the line in high impedance
    assert_start_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && cnv_rise && sdi_i) |=> (!sdo_oe_o && r_q.st == ST_CONV));
    // R4: busy indication is driven low after a clean completion
    assert_busy_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CONV && t_done && !sdi_i && !r_q.viol && !sdi_rise) |=> (sdo_oe_o && !sdo_o));
    // R6: seventeenth falling edge releases the line
    assert_release_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_READ && sck_fall && !sdi_rise && r_q.bits == BITS_END) |=> !sdo_oe_o);
    // R7: select rising during readout releases the line
    assert_release_sdi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_READ && sdi_rise) |=> !sdo_oe_o);
    // R9: a flagged conversion never produces the busy indication
    assert_viol_nobusy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CONV && r_q.viol) |=> !sdo_oe_o);
    // R5: bit counter stays within one word plus the release edge
    assert_bits_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bits <= BITS_END);
endmodule

// File: tb/sim_adci_target.sv
`timescale 1ns/1ps
module sim_adci_target;
    localparam int DW   = 16;
    localparam int CONV = 20;
    localparam int MINC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnv = 1'b0, sdi = 1'b0, sck = 1'b0;
    logic [DW-1:0] sample = '0;
    logic sdo, sdo_oe, viol;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    adci_target #(.DATA_W(DW), .CONV_CYC(CONV), .MIN_CYC(MINC)) u0 (
        .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sdi_i(sdi), .sck_i(sck),
        .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .viol_o(viol)
    );

    // behavioural reference: mode 0 idle, 1 converting, 2 reading
    int   m_mode = 0, m_t = 0;
    bit   m_oe = 0, m_dat = 0, m_viol = 0;
    bit   pc = 0, ps = 0, pk = 0;
    bit   bitq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_t = 0; m_oe = 0; m_dat = 0; m_viol = 0;
            pc = 0; ps = 0; pk = 0; bitq = {};
        end else begin
            bit cr, sr, sf;
            cr = cnv && !pc;
            sr = sdi && !ps;
            sf = !sck && pk;
            case (m_mode)
                0: if (cr && sdi) begin
                       m_mode = 1; m_t = 0; m_viol = 0; m_oe = 0;
                   end else begin
                       m_oe = !cnv && !sdi; m_dat = 0;
                   end
                1: begin
                       m_oe = 0;
                       if (sr && m_t >= MINC) m_viol = 1;
                       if (m_t == CONV - 1) begin
                           bitq = {};
                           for (int i = DW - 1; i >= 0; i--) bitq.push_back(sample[i]);
                           if (!sdi && !m_viol) begin
                               m_mode = 2; m_oe = 1; m_dat = 0;
                           end else m_mode = 0;
                       end else m_t++;
                   end
                default: if (sr) begin
                       m_oe = 0; m_mode = 0;
                   end else if (sf) begin
                       if (bitq.size() == 0) begin m_oe = 0; m_mode = 0; end
                       else m_dat = bitq.pop_front();
                   end
            endcase
            pc = cnv; ps = sdi; pk = sck;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            total++;
            if (sdo_oe !== m_oe || (m_oe && sdo !== m_dat) || viol !== m_viol) begin
                bad++;
                $display("FAIL %s model: oe=%0b dat=%0b viol=%0b expected oe=%0b dat=%0b viol=%0b",
                         phase, sdo_oe, sdo, viol, m_oe, m_dat, m_viol);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_bits(input logic [DW-1:0] w, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            sck = 1'b1; tick(1);
            sck = 1'b0; tick(1);
            chk(sdo_oe === 1'b1 && sdo === w[DW-1-i], tag, int'(sdo), int'(w[DW-1-i]));
        end
    endtask

    // raise the convert strobe with select high; caller continues from N0
    task automatic start_conv();
        sdi = 1'b1; cnv = 1'b0; tick(1);
        cnv = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset
        tick(3);
        chk(sdo_oe === 1'b0, "R1 enable", int'(sdo_oe), 0);
        chk(viol === 1'b0, "R1 violation", int'(viol), 0);
        rst_n = 1'b1;
        // R2 idle drive low / high impedance
        phase = "R2";
        tick(2);
        chk(sdo_oe === 1'b1 && sdo === 1'b0, "R2 idle low", int'(sdo_oe), 1);
        sdi = 1'b1; tick(2);
        chk(sdo_oe === 1'b0, "R2 idle hiz", int'(sdo_oe), 0);

        // R3/R4/R5/R6 full conversion and readout
        phase = "R3";
        sample = 16'hA5C3;
        start_conv();
        tick(2); sdi = 1'b0;
        chk(sdo_oe === 1'b0, "R3 converting hiz", int'(sdo_oe), 0);
        tick(18);
        chk(sdo_oe === 1'b0, "R4 not yet done", int'(sdo_oe), 0);
        phase = "R4";
        tick(1);
        chk(sdo_oe === 1'b1 && sdo === 1'b0, "R4 busy low", int'(sdo_oe), 1);
        phase = "R5";
        sample = 16'h0000;
        read_bits(16'hA5C3, 16, "R5 bit");
        phase = "R6";
        sck = 1'b1; tick(1); sck = 1'b0; tick(1);
        chk(sdo_oe === 1'b0, "R6 release 17th", int'(sdo_oe), 0);

        // R7 early release by select
        phase = "R2";
        cnv = 1'b0; tick(2);
        chk(sdo_oe === 1'b1 && sdo === 1'b0, "R2 idle low again", int'(sdo_oe), 1);
        phase = "R7";
        sample = 16'h8001;
        start_conv();
        tick(2); sdi = 1'b0; tick(19);
        read_bits(16'h8001, 5, "R7 partial bit");
        sdi = 1'b1; tick(1);
        chk(sdo_oe === 1'b0, "R7 release by select", int'(sdo_oe), 0);

        // R8 early pulse, R10 clock during conversion
        phase = "R8";
        sample = 16'h3C69;
        start_conv();
        tick(2); sdi = 1'b0; tick(1);
        sdi = 1'b1; tick(1); sdi = 1'b0;
        for (int i = 0; i < 8; i++) begin
            sck = ~sck; tick(2);
        end
        sck = 1'b0; tick(1);
        chk(sdo_oe === 1'b1 && sdo === 1'b0, "R8 busy after early pulse", int'(sdo_oe), 1);
        chk(viol === 1'b0, "R8 no violation", int'(viol), 0);
        phase = "R10";
        read_bits(16'h3C69, 16, "R10 bits after clocked conversion");
        sck = 1'b1; tick(1); sck = 1'b0; tick(1);

        // R9 late rise
        phase = "R9";
        start_conv();
        tick(2); sdi = 1'b0; tick(13);
        sdi = 1'b1; tick(6);
        chk(sdo_oe === 1'b0, "R9 no busy", int'(sdo_oe), 0);
        chk(viol === 1'b1, "R9 flag set", int'(viol), 1);
        tick(3);
        chk(viol === 1'b1, "R9 flag sticky", int'(viol), 1);
        start_conv();
        tick(1);
        chk(viol === 1'b0, "R9 flag cleared on start", int'(viol), 0);
        tick(2); sdi = 1'b0; tick(20);
        sck = 1'b1; tick(1); sck = 1'b0; tick(1);
        sdi = 1'b1; tick(2);

        // R10 clock in idle with strobe high
        phase = "R10";
        cnv = 1'b1; sdi = 1'b0; tick(2);
        for (int i = 0; i < 6; i++) begin
            sck = ~sck; tick(1);
            chk(sdo_oe === 1'b0, "R10 idle clock ignored", int'(sdo_oe), 0);
        end
        tick(2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule